// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps a small write-back cache coherent on a shared snooping bus. Each cache frame holds one line, with a tag, a data word and one of three coherence states. A frame is Invalid when it holds no copy. It is Shared when it holds a clean copy that may only be read, and memory is up to date. It is Modified when it holds the only valid copy, which may be written and is dirty. Any number of caches may hold a line in Shared at the same time. Only a Modified holder may write, and it does so with no bus traffic.

The processor side issues loads, stores and evictions and holds each request steady until the controller acknowledges it. A request that cannot complete locally becomes a single bus request, held until the bus grants it. The controller watches every snooped bus command from other agents. When another agent asks for a line this cache holds dirty, the controller gives up ownership and drives the current data on a reply output in the same cycle. Memory captures this reply as the write-back.

The frame index is taken from the low address bits and the tag from the rest. Arbitration and memory timing are handled outside the block. A grant delivers fill data on the bus read-data input in the grant cycle.

Top module: `msi_frame_ctrl`

## Requirements
- R1: After reset every frame is Invalid, no bus request and no reply is active, and a first load to any address misses and issues a bus read.
- R2: A load that hits a Shared or Modified frame with a matching tag raises cpu_ready in the same cycle, returns the frame data on cpu_rdata and makes no bus request.
- R3: A load miss requests bus read (bus_cmd 1) and holds bus_req, bus_cmd and bus_addr stable until bus_gnt. In the grant cycle cpu_ready rises and cpu_rdata equals bus_rdata. The line then sits in Shared, so a later load hits.
- R4: A store miss requests read-for-ownership (bus_cmd 2). On grant the frame becomes Modified and holds the store data.
- R5: A store that hits a Shared frame requests invalidate (bus_cmd 3) and becomes Modified with the store data on grant.
- R6: A store that hits a Modified frame completes in the same cycle with no bus request, and it updates the data.
- R7: A snooped bus read (snoop_cmd 1) to a line held Modified raises reply_valid in the same cycle with that line's data, and the frame drops to Shared. A later store to it must then request invalidate.
- R8: A snooped read-for-ownership (2) or invalidate (3) to a held line sends the frame to Invalid, and a Modified frame supplies reply data in that cycle. A Shared frame gives no reply, and a snooped read to a Shared frame changes nothing.
- R9: Evicting a Modified line requests write-back (bus_cmd 4) with that line's address and data on bus_addr and bus_wdata, and the frame is Invalid after the grant. Evicting a Shared line completes in the same cycle with no bus traffic, and the frame becomes Invalid.
- R10: A load or store that misses on a frame holding a different Modified line first writes that line back at its own address without acknowledging the processor. It then issues the request for the new line.
- R11: If a snooped read-for-ownership or invalidate hits the line of a pending invalidate request, the pending request turns into a read-for-ownership.
- R12: Encodings: cpu_op 0 load, 1 store, 2 evict. bus_cmd is 0 when no request is active. In a cycle with snoop_valid high, neither cpu_ready nor a grant takes effect, and at most one bus request is outstanding.
- R13: If a snoop strips a Modified line whose write-back is pending, the request is withdrawn. A pending eviction then completes locally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cpu_valid | input | 1 | processor request present, held until cpu_ready |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict |
| cpu_addr | input | ADDR_W | line address; low bits pick the frame |
| cpu_wdata | input | DATA_W | store data |
| cpu_ready | output | 1 | request completes this cycle |
| cpu_rdata | output | DATA_W | load data, valid with cpu_ready |
| bus_req | output | 1 | bus request outstanding |
| bus_cmd | output | 3 | 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | address of the request |
| bus_wdata | output | DATA_W | write-back data |
| bus_gnt | input | 1 | request served this cycle |
| bus_rdata | input | DATA_W | fill data in the grant cycle |
| snoop_valid | input | 1 | other agent's command on the bus |
| snoop_cmd | input | 3 | snooped command, same codes as bus_cmd |
| snoop_addr | input | ADDR_W | snooped address |
| reply_valid | output | 1 | dirty data supplied this cycle |
| reply_data | output | DATA_W | supplied data |

## Verification
The hardest case to reach is a snoop that arrives while the controller's own request waits for a grant. Examples are an invalidate that races an upgrade, or a read-for-ownership that steals a line whose write-back is pending. The bench first steers the frame into Shared or Modified through ordinary loads and stores. It then issues the request and leaves bus_gnt low, injects the snoop in that waiting cycle, and only afterwards checks the command that remains on the bus before it grants. Victim write-back needs a Modified line and a miss to the same frame under another tag, and the bench builds both on purpose.

// File: rtl/msi_frame_ctrl.sv
module msi_frame_ctrl #(
  parameter int FRAMES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [2:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              reply_valid,
  output logic [DATA_W-1:0] reply_data
);
  localparam int IDX_W = $clog2(FRAMES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_EV = 2'd2;
  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_RDX = 3'd2, C_INV = 3'd3, C_WB = 3'd4;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;

  logic [1:0]        fst  [FRAMES];
  logic [TAG_W-1:0]  ftag [FRAMES];
  logic [DATA_W-1:0] fdat [FRAMES];

  logic              busy, pvict;
  logic [2:0]        pcmd;
  logic [ADDR_W-1:0] paddr;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snoop_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snoop_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] p_idx = paddr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = paddr[ADDR_W-1:IDX_W];

  wire [1:0] c_st  = fst[c_idx];
  wire [1:0] s_st  = fst[s_idx];
  wire       c_hit = (c_st != ST_I) && (ftag[c_idx] == c_tag);
  wire       s_hit = snoop_valid && (s_st != ST_I) && (ftag[s_idx] == s_tag);
  wire       s_own = (snoop_cmd == C_RDX) || (snoop_cmd == C_INV);
  wire       grant = busy && bus_gnt && !snoop_valid;

  logic              local_done, issue, ivict;
  logic [2:0]        icmd;
  logic [ADDR_W-1:0] iaddr;

  always_comb begin
    local_done = 1'b0;
    issue      = 1'b0;
    ivict      = 1'b0;
    icmd       = C_NONE;
    iaddr      = cpu_addr;
    if (cpu_valid && !busy && !snoop_valid) begin
      case (cpu_op)
        OP_LD: begin
          if (c_hit) local_done = 1'b1;
          else begin
            issue = 1'b1;
            if (c_st == ST_M) begin
              icmd = C_WB; ivict = 1'b1; iaddr = {ftag[c_idx], c_idx};
            end else icmd = C_RD;
          end
        end
        OP_ST: begin
          if (c_hit && c_st == ST_M) local_done = 1'b1;
          else begin
            issue = 1'b1;
            if (c_hit) icmd = C_INV;
            else if (c_st == ST_M) begin
              icmd = C_WB; ivict = 1'b1; iaddr = {ftag[c_idx], c_idx};
            end else icmd = C_RDX;
          end
        end
        OP_EV: begin
          if (c_hit && c_st == ST_M) begin
            issue = 1'b1; icmd = C_WB;
          end else local_done = 1'b1;
        end
        default: local_done = 1'b1;
      endcase
    end
  end

  assign cpu_ready   = local_done || (grant && !pvict);
  assign cpu_rdata   = busy ? bus_rdata : fdat[c_idx];
  assign bus_req     = busy;
  assign bus_cmd     = busy ? pcmd : C_NONE;
  assign bus_addr    = paddr;
  assign bus_wdata   = fdat[p_idx];
  assign reply_valid = s_hit && (s_st == ST_M) && (s_own || snoop_cmd == C_RD);
  assign reply_data  = fdat[s_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pvict <= 1'b0;
      pcmd  <= C_NONE;
      paddr <= '0;
      for (int i = 0; i < FRAMES; i++) begin
        fst[i]  <= ST_I;
        ftag[i] <= '0;
        fdat[i] <= '0;
      end
    end else begin
      if (s_hit) begin
        if (s_own) fst[s_idx] <= ST_I;
        else if (snoop_cmd == C_RD && s_st == ST_M) fst[s_idx] <= ST_S;
        if (busy && paddr == snoop_addr) begin
          if (pcmd == C_INV && s_own) pcmd <= C_RDX;
          if (pcmd == C_WB && reply_valid) begin
            busy <= 1'b0;
            pcmd <= C_NONE;
          end
        end
      end
      if (issue) begin
        busy  <= 1'b1;
        pcmd  <= icmd;
        paddr <= iaddr;
        pvict <= ivict;
      end
      if (local_done && cpu_op == OP_ST) fdat[c_idx] <= cpu_wdata;
      if (local_done && cpu_op == OP_EV && c_hit) fst[c_idx] <= ST_I;
      if (grant) begin
        busy <= 1'b0;
        pcmd <= C_NONE;
        case (pcmd)
          C_RD: begin
            fst[p_idx]  <= ST_S;
            ftag[p_idx] <= p_tag;
            fdat[p_idx] <= bus_rdata;
          end
          C_RDX, C_INV: begin
            fst[p_idx]  <= ST_M;
            ftag[p_idx] <= p_tag;
            fdat[p_idx] <= cpu_wdata;
          end
          C_WB: fst[p_idx] <= ST_I;
          default: ;
        endcase
      end
    end
  end
endmodule

module msi_frame_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic [1:0]        cpu_op,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [2:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snoop_valid,
  input logic [2:0]        snoop_cmd,
  input logic              reply_valid,
  input logic [DATA_W-1:0] reply_data
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snoop_valid) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd))); // R3
  AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_cmd == 3'd0)); // R12
  AST_SNOOP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> !cpu_ready); // R12
  AST_REPLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> (snoop_valid && snoop_cmd >= 3'd1 && snoop_cmd <= 3'd3)); // R7
  AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid); // R2
  AST_LOAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && bus_req && cpu_op == 2'd0) |-> (bus_cmd == 3'd1)); // R3
  AST_STORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && bus_req && cpu_op == 2'd1) |-> (bus_cmd == 3'd2 || bus_cmd == 3'd3)); // R4
  AST_REPLY_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> !$isunknown(reply_data)); // R8
endmodule

bind msi_frame_ctrl msi_frame_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .reply_valid(reply_valid),
  .reply_data(reply_data));

// File: tb/sim_msi_frame_ctrl.sv
module sim_msi_frame_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [7:0]  cpu_addr = 8'd0;
  logic [15:0] cpu_wdata = 16'd0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        bus_req;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_gnt = 1'b0;
  logic [15:0] bus_rdata = 16'd0;
  logic        snoop_valid = 1'b0;
  logic [2:0]  snoop_cmd = 3'd0;
  logic [7:0]  snoop_addr = 8'd0;
  logic        reply_valid;
  logic [15:0] reply_data;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  msi_frame_ctrl u0 (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [15:0] fill;
    logic [2:0]  ecmd;
    logic [15:0] erd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h10, 16'h0000, 16'hAAAA, 3'd1, 16'hAAAA, 4'd3},  // R3 load miss
    '{2'd0, 8'h10, 16'h0000, 16'h0000, 3'd0, 16'hAAAA, 4'd2},  // R2 load hit
    '{2'd1, 8'h10, 16'h1111, 16'h0000, 3'd3, 16'h0000, 4'd5},  // R5 upgrade
    '{2'd1, 8'h10, 16'h2222, 16'h0000, 3'd0, 16'h0000, 4'd6},  // R6 local store
    '{2'd0, 8'h10, 16'h0000, 16'h0000, 3'd0, 16'h2222, 4'd6},  // R6 data kept
    '{2'd1, 8'h21, 16'h3333, 16'h0000, 3'd2, 16'h0000, 4'd4},  // R4 store miss
    '{2'd0, 8'h21, 16'h0000, 16'h0000, 3'd0, 16'h3333, 4'd4},  // R4 data in M
    '{2'd2, 8'h21, 16'h0000, 16'h0000, 3'd4, 16'h3333, 4'd9},  // R9 evict M
    '{2'd0, 8'h21, 16'h0000, 16'h4444, 3'd1, 16'h4444, 4'd9},  // R9 now invalid
    '{2'd2, 8'h21, 16'h0000, 16'h0000, 3'd0, 16'h0000, 4'd9},  // R9 silent evict
    '{2'd0, 8'h21, 16'h0000, 16'h5555, 3'd1, 16'h5555, 4'd9},  // R9 invalid again
    '{2'd0, 8'h12, 16'h0000, 16'h6666, 3'd1, 16'h6666, 4'd3}   // R3 other frame
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic op(input logic [1:0] o, input logic [7:0] a, input logic [15:0] wd,
                    input logic [15:0] fill, input logic [2:0] ecmd, input logic [15:0] erd,
                    input string rq);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = o; cpu_addr = a; cpu_wdata = wd;
    #1;
    if (ecmd == 3'd0) begin
      chk(cpu_ready, 1, rq);
      chk(bus_req, 0, rq);
      if (o == 2'd0) chk(cpu_rdata, erd, rq);
      @(negedge clk);
      cpu_valid = 1'b0;
    end else begin
      chk(cpu_ready, 0, rq);
      @(negedge clk);
      chk(bus_req, 1, rq);
      chk(bus_cmd, ecmd, rq);
      chk(bus_addr, a, rq);
      if (ecmd == 3'd4) chk(bus_wdata, erd, rq);
      bus_gnt = 1'b1; bus_rdata = fill;
      #1;
      chk(cpu_ready, 1, rq);
      if (o == 2'd0) chk(cpu_rdata, erd, rq);
      @(negedge clk);
      bus_gnt = 1'b0; cpu_valid = 1'b0;
    end
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a,
                       input logic erv, input logic [15:0] erd, input string rq);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a;
    #1;
    chk(reply_valid, erv, rq);
    if (erv) chk(reply_data, erd, rq);
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_req, 0, "R1");
    chk(reply_valid, 0, "R1");
    chk(cpu_ready, 0, "R1");
    chk(bus_cmd, 0, "R1");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      op(TBL[i].op, TBL[i].addr, TBL[i].wd, TBL[i].fill, TBL[i].ecmd, TBL[i].erd,
         $sformatf("R%0d", TBL[i].rq));

    // R7 snooped read on Modified line 0x10 (data 2222) -> reply, Shared
    snoop(3'd1, 8'h10, 1'b1, 16'h2222, "R7");
    op(2'd1, 8'h10, 16'h7777, 16'h0, 3'd3, 16'h0, "R7");

    // R8 snooped read-for-ownership on Modified, then invalidate on Shared
    snoop(3'd2, 8'h10, 1'b1, 16'h7777, "R8");
    op(2'd0, 8'h10, 16'h0, 16'h8888, 3'd1, 16'h8888, "R8");
    snoop(3'd3, 8'h10, 1'b0, 16'h0, "R8");
    op(2'd0, 8'h10, 16'h0, 16'h9999, 3'd1, 16'h9999, "R8");
    snoop(3'd1, 8'h10, 1'b0, 16'h0, "R8");
    op(2'd0, 8'h10, 16'h0, 16'h0, 3'd0, 16'h9999, "R8");

    // R10 victim write-back before fill
    op(2'd1, 8'h10, 16'hABCD, 16'h0, 3'd3, 16'h0, "R10");
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = 8'h14;
    #1 chk(cpu_ready, 0, "R10");
    @(negedge clk);
    chk(bus_cmd, 4, "R10");
    chk(bus_addr, 8'h10, "R10");
    chk(bus_wdata, 16'hABCD, "R10");
    bus_gnt = 1'b1;
    #1 chk(cpu_ready, 0, "R10");
    @(negedge clk);
    bus_gnt = 1'b0;
    @(negedge clk);
    chk(bus_cmd, 1, "R10");
    chk(bus_addr, 8'h14, "R10");
    bus_gnt = 1'b1; bus_rdata = 16'h1357;
    #1;
    chk(cpu_ready, 1, "R10");
    chk(cpu_rdata, 16'h1357, "R10");
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;

    // R11 pending upgrade on 0x12 (Shared) hit by snooped invalidate
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd1; cpu_addr = 8'h12; cpu_wdata = 16'h2468;
    @(negedge clk);
    chk(bus_cmd, 3, "R11");
    snoop_valid = 1'b1; snoop_cmd = 3'd3; snoop_addr = 8'h12;
    #1 chk(reply_valid, 0, "R11");
    @(negedge clk);
    snoop_valid = 1'b0;
    chk(bus_cmd, 2, "R11");
    bus_gnt = 1'b1;
    #1 chk(cpu_ready, 1, "R11");
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;
    op(2'd0, 8'h12, 16'h0, 16'h0, 3'd0, 16'h2468, "R11");

    // R12 snoop cycle blocks local completion and grant
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = 8'h12;
    snoop_valid = 1'b1; snoop_cmd = 3'd1; snoop_addr = 8'h33;
    #1 chk(cpu_ready, 0, "R12");
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk(cpu_ready, 1, "R12");
    chk(cpu_rdata, 16'h2468, "R12");
    @(negedge clk);
    cpu_addr = 8'h33;
    @(negedge clk);
    chk(bus_cmd, 1, "R12");
    bus_gnt = 1'b1; bus_rdata = 16'hC0DE;
    snoop_valid = 1'b1; snoop_cmd = 3'd1; snoop_addr = 8'h20;
    #1 chk(cpu_ready, 0, "R12");
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk(cpu_ready, 1, "R12");
    chk(cpu_rdata, 16'hC0DE, "R12");
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;

    // R13 pending eviction of Modified 0x12 stolen by snoop
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd2; cpu_addr = 8'h12;
    @(negedge clk);
    chk(bus_cmd, 4, "R13");
    snoop_valid = 1'b1; snoop_cmd = 3'd2; snoop_addr = 8'h12;
    #1;
    chk(reply_valid, 1, "R13");
    chk(reply_data, 16'h2468, "R13");
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk(bus_req, 0, "R13");
    chk(cpu_ready, 1, "R13");
    @(negedge clk);
    cpu_valid = 1'b0;

    // R1 reset mid-run clears held lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_req, 0, "R1");
    rst_n = 1'b1;
    op(2'd0, 8'h14, 16'h0, 16'h0F0F, 3'd1, 16'h0F0F, "R1");

    finish_run();
  end
endmodule